// File: doc/BRIEF.md
# Decimating Sample Write-Strobe Generator

This block sits beside a free-running sampling clock and produces an active-low FIFO write strobe. A sample is committed only when the strobe is low at a rising edge of the sampling clock. Holding the strobe low commits every sample. Pulsing it low once every N cycles commits one sample in N, and holding it high commits nothing. The block neither divides nor gates the sampling clock. It uses that clock only to time the strobe, so the clock stays continuous through every change of rate.

A host sets the rate through a small serial slave port. The host raises a select line and shifts one command byte in, MSB first, on the rising edges of its serial clock. At the same time it reads a status byte back on a transmit line, MSB first, which changes on the falling serial-clock edges. It then drops select. All serial inputs pass through two-flop synchronizers into the sampling-clock domain, and their edges are detected there. The serial clock must therefore run slower than a quarter of the sampling clock.

The decimation controller has two states. It moves from HALT to RUN when it takes up a code from 0 to 7, and from RUN to HALT when it takes up code 8. The serial port moves from IDLE to SHIFT when select rises, and from SHIFT back to IDLE when select falls. A new rate is only ever taken up at a counter wrap, so no strobe pulse is shortened or doubled.

Top module: `sample_strobe_gen`

## Requirements
- R1: After reset the strobe `wr_n` is high, the active rate code is 8 (nothing committed) and the status invalid flag is clear, so the first status byte read is 0x08.
- R2: With code 0 active, `wr_n` stays low on every sampling clock cycle.
- R3: Codes 1 to 7 select ratios 2, 4, 10, 20, 40, 100 and 200; `wr_n` is then low for exactly one cycle out of each ratio cycles (code 0 is ratio 1).
- R4: With code 8 active, `wr_n` stays high indefinitely.
- R5: A command counts only if exactly 8 serial-clock rising edges occur while select is high; bits are taken MSB first from `cfg_rxd` at those edges; any other bit count leaves rate and status flag unchanged.
- R6: A complete command with a value above 8 is ignored (rate unchanged) and sets status bit 7; the next valid command clears it.
- R7: The status byte is {invalid flag, 3'b000, active code[3:0]}, captured when select rises, presented MSB first on `cfg_txd`, first bit available right after select rises, each next bit after a serial-clock falling edge.
- R8: A new rate is taken up only where the running counter wraps (last cycle of a period) or at once if halted; the counter restarts so the first strobe of the new rate falls in the cycle of the switch.
- R9: If the controller is free to switch, a valid command takes effect at the fourth sampling-clock rising edge after select falls; `wr_n` reflects the new rate right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Serial transaction select, active high |
| cfg_sck | input | 1 | Host serial clock |
| cfg_rxd | input | 1 | Serial command data from host |
| cfg_txd | output | 1 | Serial status data to host |
| wr_n | output | 1 | Active-low FIFO write strobe |

## Verification
The hardest situation to reach is a rate change that arrives while a slow ratio is partway through its period. The switch must then wait for the wrap rather than cut the period short. The bench programs ratio 200, lets it settle, and sends a ratio-4 command well before the wrap. A behavioural model that knows the fixed four-edge command latency predicts the exact cycle of the switch. The same model compares `wr_n` on every cycle, so truncated, aborted and out-of-range commands show up as strobe mismatches, not only as status values.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
    localparam int CODE_W    = 4;
    localparam int CNT_W     = 8;
    localparam int CMD_W     = 8;
    localparam logic [CODE_W-1:0] CODE_HALT = 4'd8;

    typedef enum logic {ST_HALT, ST_RUN} dec_state_e;
    typedef enum logic {SP_IDLE, SP_SHIFT} sp_state_e;

    function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            4'd0:    r = 8'd1;
            4'd1:    r = 8'd2;
            4'd2:    r = 8'd4;
            4'd3:    r = 8'd10;
            4'd4:    r = 8'd20;
            4'd5:    r = 8'd40;
            4'd6:    r = 8'd100;
            4'd7:    r = 8'd200;
            default: r = 8'd0;
        endcase
        return r;
    endfunction

    function automatic logic code_ok(input logic [CMD_W-1:0] cmd);
        return cmd <= CMD_W'(CODE_HALT);
    endfunction
endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [STAGES:0][N-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/ssg_serial.sv
module ssg_serial
    import ssg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_rise,
    input  logic              sel_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              rxd,
    input  logic [CODE_W-1:0] active_code,
    output logic              txd,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code
);
    sp_state_e        state, state_n;
    logic [3:0]       bit_cnt;
    logic [CMD_W-1:0] rx_sr, tx_sr;
    logic             bad_q;

    always_comb begin
        state_n = state;
        unique case (state)
            SP_IDLE:  if (sel_rise) state_n = SP_SHIFT;
            SP_SHIFT: if (sel_fall) state_n = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            bad_q     <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_code  <= CODE_HALT;
        end else begin
            cmd_valid <= 1'b0;
            unique case (state)
                SP_IDLE: begin
                    if (sel_rise) begin
                        tx_sr   <= {bad_q, 3'b000, active_code};
                        bit_cnt <= '0;
                    end
                end
                SP_SHIFT: begin
                    if (sel_fall) begin
                        if (bit_cnt == 4'd8) begin
                            if (code_ok(rx_sr)) begin
                                cmd_valid <= 1'b1;
                                cmd_code  <= rx_sr[CODE_W-1:0];
                                bad_q     <= 1'b0;
                            end else begin
                                bad_q     <= 1'b1;
                            end
                        end
                    end else begin
                        if (sck_rise) begin
                            rx_sr <= {rx_sr[CMD_W-2:0], rxd};
                            if (bit_cnt != 4'd15) bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (sck_fall) tx_sr <= {tx_sr[CMD_W-2:0], 1'b0};
                    end
                end
            endcase
        end
    end

    assign txd = tx_sr[CMD_W-1];

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_fall || sel_rise) |=> $stable(tx_sr));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !bad_q);
endmodule

// File: rtl/ssg_decim.sv
module ssg_decim
    import ssg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              wr_n,
    output logic [CODE_W-1:0] active_code
);
    dec_state_e        state, state_n;
    logic [CODE_W-1:0] active_q, active_n, next_q, next_n, take_code;
    logic [CNT_W-1:0]  cnt_q, cnt_n, ratio;
    logic              pend_q, pend_n, take, at_wrap, wr_n_q;

    assign ratio     = ratio_of(active_q);
    assign at_wrap   = (state == ST_HALT) || (cnt_q == ratio - 8'd1);
    assign take      = cmd_valid | pend_q;
    assign take_code = cmd_valid ? cmd_code : next_q;

    always_comb begin
        state_n  = state;
        active_n = active_q;
        next_n   = next_q;
        pend_n   = pend_q;
        cnt_n    = cnt_q;
        if (take && at_wrap) begin
            active_n = take_code;
            cnt_n    = '0;
            pend_n   = 1'b0;
            state_n  = (take_code == CODE_HALT) ? ST_HALT : ST_RUN;
        end else begin
            pend_n = take;
            next_n = take_code;
            unique case (state)
                ST_HALT: cnt_n = '0;
                ST_RUN:  cnt_n = at_wrap ? '0 : cnt_q + 8'd1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HALT;
            active_q <= CODE_HALT;
            next_q   <= CODE_HALT;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            state    <= state_n;
            active_q <= active_n;
            next_q   <= next_n;
            pend_q   <= pend_n;
            cnt_q    <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= !((state_n == ST_RUN) && (cnt_n == '0));
    end

    assign wr_n        = wr_n_q;
    assign active_code = active_q;

    // R4
    halt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> wr_n_q);

    // R2
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && active_q == 4'd0) |-> !wr_n_q);

    // R3
    single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && active_q != 4'd0 && !wr_n_q) |=> wr_n_q);

    // R8
    switch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> $past(at_wrap));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt_q < ratio));
endmodule

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen
    import ssg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_sel,
    input  logic cfg_sck,
    input  logic cfg_rxd,
    output logic cfg_txd,
    output logic wr_n
);
    logic [2:0]        s_level, s_rise, s_fall;
    logic              cmd_valid;
    logic [CODE_W-1:0] cmd_code, active_code;

    ssg_sync #(.N(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cfg_rxd, cfg_sck, cfg_sel}),
        .level (s_level),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    ssg_serial u_serial (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_rise    (s_rise[0]),
        .sel_fall    (s_fall[0]),
        .sck_rise    (s_rise[1]),
        .sck_fall    (s_fall[1]),
        .rxd         (s_level[2]),
        .active_code (active_code),
        .txd         (cfg_txd),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code)
    );

    ssg_decim u_decim (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .wr_n        (wr_n),
        .active_code (active_code)
    );
endmodule

// File: tb/sample_strobe_gen_bench.sv
module sample_strobe_gen_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 1'b0, sck = 1'b0, rxd = 1'b0;
    wire  txd, wr_n;

    sample_strobe_gen u_sample_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_sel(sel), .cfg_sck(sck),
        .cfg_rxd(rxd), .cfg_txd(txd), .wr_n(wr_n)
    );

    always #5 clk = ~clk;

    int    checks = 0, fails = 0, edge_cnt = 0;
    int    m_ratio = 0, m_phase = 0, m_new = 0, m_apply = 0;
    bit    m_pend = 0, m_exp = 1, cmp_en = 0;
    string tag = "R8";

    function automatic int ratio_f(int c);
        case (c)
            0: return 1;   1: return 2;   2: return 4;   3: return 10;
            4: return 20;  5: return 40;  6: return 100; 7: return 200;
            default: return 0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference of the strobe
    always @(posedge clk) begin
        edge_cnt++;
        if (!rst_n) begin
            m_ratio = 0; m_phase = 0; m_exp = 1;
        end else begin
            if (m_pend && edge_cnt >= m_apply && (m_ratio == 0 || m_phase == m_ratio - 1)) begin
                m_ratio = ratio_f(m_new); m_phase = 0; m_pend = 0;
            end else if (m_ratio != 0) begin
                m_phase = (m_phase == m_ratio - 1) ? 0 : m_phase + 1;
            end
            m_exp = !(m_ratio != 0 && m_phase == 0);
        end
    end

    always @(negedge clk)
        if (rst_n && cmp_en) check(wr_n === m_exp, tag, int'(wr_n), int'(m_exp));

    task automatic xfer(input logic [7:0] cmd, input int nbits, output logic [7:0] st);
        st = 8'h00;
        @(negedge clk) sel = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; rxd = cmd[7-i];
            repeat (6) @(negedge clk);
            st[7-i] = txd;
            sck = 1'b1;
            repeat (6) @(negedge clk);
        end
        sel = 1'b0;
        if (nbits == 8 && cmd <= 8) begin
            m_pend = 1; m_new = int'(cmd); m_apply = edge_cnt + 4;
        end
        repeat (3) @(negedge clk);
        sck = 1'b0; rxd = 1'b0;
    endtask

    task automatic count_low(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (!wr_n) c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] st;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_n === 1'b1, "R1", int'(wr_n), 1);
        cmp_en = 1;

        tag = "R9";
        xfer(8'h00, 8, st);
        check(st == 8'h08, "R1", st, 8'h08);
        repeat (450) @(negedge clk);
        count_low(400, n);
        check(n == 400, "R2", n, 400);

        for (int c = 1; c <= 8; c++) begin
            tag = "R8";
            xfer(8'(c), 8, st);
            check(st == 8'(c - 1), "R7", st, c - 1);
            repeat (450) @(negedge clk);
            count_low(400, n);
            if (c == 8) check(n == 0, "R4", n, 0);
            else        check(n == 400 / ratio_f(c), "R3", n, 400 / ratio_f(c));
        end

        tag = "R9";
        xfer(8'h07, 8, st);
        check(st == 8'h08, "R7", st, 8'h08);
        repeat (250) @(negedge clk);
        tag = "R8";
        xfer(8'h02, 8, st);
        check(st == 8'h07, "R7", st, 8'h07);
        repeat (450) @(negedge clk);

        tag = "R6";
        xfer(8'h0C, 8, st);
        check(st == 8'h02, "R7", st, 8'h02);
        repeat (50) @(negedge clk);
        xfer(8'hC8, 8, st);
        check(st == 8'h82, "R6", st, 8'h82);
        repeat (50) @(negedge clk);

        tag = "R5";
        xfer(8'h00, 5, st);
        check(st == 8'h80, "R5", st, 8'h80);
        repeat (100) @(negedge clk);
        xfer(8'h01, 8, st);
        check(st == 8'h82, "R5", st, 8'h82);
        repeat (450) @(negedge clk);
        xfer(8'h08, 8, st);
        check(st == 8'h01, "R6", st, 8'h01);
        repeat (450) @(negedge clk);
        count_low(200, n);
        check(n == 0, "R4", n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule